// File: doc/BRIEF.md
# Three-Channel Timer Register Bank

This block gathers three timer channels behind one 32-bit register port driven by single-cycle read and write strobes. Registers of the same kind sit in groups of three consecutive words, one word per channel. The block splits each byte offset into a channel index and a register kind. It keeps each channel's settings and counter, and it raises a separate interrupt line for each channel.

Each channel counts up or down by one per clock while it is enabled. It can run free over the full 16-bit range or wrap at a programmed interval, and it can compare its count against three match values. Events set bits in a per-channel status word. A status bit drives the channel's interrupt line when its matching enable bit is set. Reading the status word returns the flags and clears them in the same access.

Top module: `tri_timer_bank`

## Requirements
- R1: The word offset is the byte address shifted right by 2. The channel is the word offset modulo 3, and the register kind is the word offset divided by 3. Kinds 0..10 are, in order: clock setup, counter control, count, interval, match A, match B, match C, status, interrupt enable, event setup and event value. A write changes only the addressed channel's register.
- R2: Read data appears on rdData in the cycle after rdEn is sampled and is then held. After reset, counter control reads 0x21 and every other register reads 0.
- R3: Writes keep the low 6 bits for clock setup, counter control and interrupt enable, the low 16 bits for interval and the match registers, and the low 3 bits for event setup.
- R4: Writes to the status, count and event value kinds have no effect. Event value always reads 0.
- R5: A word offset of 33 or more reads 0, and a write to it changes no register.
- R6: A count read returns the 16-bit count with bits 31:16 at zero.
- R7: A status read returns the flags that were set before the read and clears them at the same edge, so the channel's interrupt drops.
- R8: A flag that is raised at the same edge as a status read is kept and remains visible after the clear.
- R9: irq[c] is high exactly when channel c has a status bit set whose interrupt enable bit is also set. Each channel's line is independent of the others.
- R10: Counter control bit 0 set stops the count, and when it is clear the count steps once per clock. Writing counter control with bit 4 set zeroes the count, and bit 4 is not stored.
- R11: Counter control bit 2 selects counting down. When bit 1 is set the count wraps at the interval value and sets status bit 0. When bit 1 is clear it wraps at 0xFFFF and sets status bit 4. Counting up from the limit goes to 0, and counting down from 0 goes to the limit.
- R12: With counter control bit 3 set, a stepped count equal to match A, B or C sets status bit 1, 2 or 3 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
A register write takes effect at the edge that samples the strobe. Read data is due one edge after rdEn, so each read task asserts the strobe at a falling edge and captures rdData at the following falling edge. Counter events are due a fixed number of edges after the control write that zeroes the count: an interval of 4 flags at the fifth edge, a match of 3 at the third edge, and a down count from zero at the first edge. Each scenario waits exactly that many falling edges and checks the interrupt line one edge early and then on time. The same-edge collision is set up by issuing a status read timed to land on the fifth edge after the control write.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int CNT_W     = 16;
  localparam int CTL_W     = 6;
  localparam int EVT_W     = 3;
  localparam int NUM_MATCH = 3;
  localparam int NUM_REGS  = 11;
  localparam int CHF_W     = 4;

  localparam int F_INTV   = 0;
  localparam int F_MATCH0 = 1;
  localparam int F_OVF    = 4;

  localparam int C_STOP  = 0;
  localparam int C_INTV  = 1;
  localparam int C_DOWN  = 2;
  localparam int C_MATCH = 3;
  localparam int C_ZERO  = 4;

  typedef enum logic [3:0] {
    R_CLK    = 4'd0,
    R_CNTCTL = 4'd1,
    R_COUNT  = 4'd2,
    R_INTV   = 4'd3,
    R_MATCHA = 4'd4,
    R_MATCHB = 4'd5,
    R_MATCHC = 4'd6,
    R_STATUS = 4'd7,
    R_INTEN  = 4'd8,
    R_EVTCTL = 4'd9,
    R_EVTVAL = 4'd10
  } regSel_e;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             hit;
    regSel_e          regSel;
    logic [CHF_W-1:0] ch;
  } bankStrobe_t;

  typedef struct packed {
    logic [CTL_W-1:0]                  clkCtl;
    logic [CTL_W-1:0]                  cntCtl;
    logic [CNT_W-1:0]                  count;
    logic [CNT_W-1:0]                  interval;
    logic [NUM_MATCH-1:0][CNT_W-1:0]   match;
    logic [CTL_W-1:0]                  flags;
    logic [CTL_W-1:0]                  intEn;
    logic [EVT_W-1:0]                  evtCtl;
  } chanView_t;
endpackage

// File: rtl/ttb_decode.sv
module ttb_decode
  import ttb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobe_t       st
);
  localparam int WOFF_W = ADDR_W - 2;
  localparam logic [WOFF_W-1:0] NCH = WOFF_W'(NUM_CH);

  logic [WOFF_W-1:0] wordOff;
  logic [WOFF_W-1:0] regIdx;
  wire unusedLow = ^addr[1:0];

  assign wordOff = addr[ADDR_W-1:2];
  assign regIdx  = wordOff / NCH;

  always_comb begin
    st.wr     = wrEn;
    st.rd     = rdEn;
    st.hit    = regIdx < WOFF_W'(NUM_REGS);
    st.regSel = regSel_e'(regIdx[3:0]);
    st.ch     = CHF_W'(wordOff % NCH);
  end
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
  import ttb_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bankStrobe_t      st,
  input  logic [CNT_W-1:0] wrData,
  output chanView_t        view,
  output logic             irq
);
  logic sel, wrHit, rdClear;
  logic [CNT_W-1:0] countNext, limit;
  logic [CTL_W-1:0] newFlags;
  logic wrap;

  assign sel     = st.hit && (st.ch == CHF_W'(CH_IDX));
  assign wrHit   = st.wr && sel;
  assign rdClear = st.rd && sel && (st.regSel == R_STATUS);

  always_comb begin
    countNext = view.count;
    newFlags  = '0;
    wrap      = 1'b0;
    limit     = view.cntCtl[C_INTV] ? view.interval : '1;
    if (!view.cntCtl[C_STOP]) begin
      if (view.cntCtl[C_DOWN]) begin
        if (view.count == '0) begin
          countNext = limit;
          wrap = 1'b1;
        end else begin
          countNext = view.count - 1'b1;
        end
      end else begin
        if (view.count >= limit) begin
          countNext = '0;
          wrap = 1'b1;
        end else begin
          countNext = view.count + 1'b1;
        end
      end
      if (wrap) newFlags[view.cntCtl[C_INTV] ? F_INTV : F_OVF] = 1'b1;
      if (view.cntCtl[C_MATCH]) begin
        for (int i = 0; i < NUM_MATCH; i++) begin
          if (countNext == view.match[i]) newFlags[F_MATCH0 + i] = 1'b1;
        end
      end
    end
    if (wrHit && st.regSel == R_CNTCTL && wrData[C_ZERO]) countNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      view.clkCtl   <= '0;
      view.cntCtl   <= CTL_W'(6'h21);
      view.count    <= '0;
      view.interval <= '0;
      view.match    <= '0;
      view.flags    <= '0;
      view.intEn    <= '0;
      view.evtCtl   <= '0;
    end else begin
      view.count <= countNext;
      view.flags <= (rdClear ? '0 : view.flags) | newFlags;
      if (wrHit) begin
        case (st.regSel)
          R_CLK:    view.clkCtl   <= wrData[CTL_W-1:0];
          R_CNTCTL: view.cntCtl   <= wrData[CTL_W-1:0] & ~(CTL_W'(1) << C_ZERO);
          R_INTV:   view.interval <= wrData;
          R_INTEN:  view.intEn    <= wrData[CTL_W-1:0];
          R_EVTCTL: view.evtCtl   <= wrData[EVT_W-1:0];
          default: ;
        endcase
        for (int i = 0; i < NUM_MATCH; i++) begin
          if (st.regSel == regSel_e'(4'(R_MATCHA) + 4'(i))) view.match[i] <= wrData;
        end
      end
    end
  end

  assign irq = |(view.flags & view.intEn);
endmodule

// File: rtl/ttb_regfile.sv
module ttb_regfile
  import ttb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStrobe_t       st,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq
);
  chanView_t views [NUM_CH];
  chanView_t selView;
  logic [DATA_W-1:0] rdMux;
  wire unusedHigh = ^wrData[DATA_W-1:CNT_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    ttb_channel #(.CH_IDX(c)) uChan (
      .clk    (clk),
      .rst_n  (rst_n),
      .st     (st),
      .wrData (wrData[CNT_W-1:0]),
      .view   (views[c]),
      .irq    (irq[c])
    );
  end

  always_comb begin
    selView = views[0];
    for (int c = 0; c < NUM_CH; c++) begin
      if (st.ch == CHF_W'(c)) selView = views[c];
    end
    case (st.regSel)
      R_CLK:    rdMux = DATA_W'(selView.clkCtl);
      R_CNTCTL: rdMux = DATA_W'(selView.cntCtl);
      R_COUNT:  rdMux = DATA_W'(selView.count);
      R_INTV:   rdMux = DATA_W'(selView.interval);
      R_MATCHA: rdMux = DATA_W'(selView.match[0]);
      R_MATCHB: rdMux = DATA_W'(selView.match[1]);
      R_MATCHC: rdMux = DATA_W'(selView.match[2]);
      R_STATUS: rdMux = DATA_W'(selView.flags);
      R_INTEN:  rdMux = DATA_W'(selView.intEn);
      R_EVTCTL: rdMux = DATA_W'(selView.evtCtl);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdData <= '0;
    else if (st.rd) rdData <= st.hit ? rdMux : '0;
  end
endmodule

// File: rtl/tri_timer_bank.sv
module tri_timer_bank
  import ttb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq
);
  bankStrobe_t st;

  ttb_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) uDecode (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .st   (st)
  );

  ttb_regfile #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) uRegs (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData
);
  int unsigned kind;
  wire unusedLow = ^addr[1:0];
  assign kind = int'(addr[ADDR_W-1:2]) / NUM_CH;

  // R5
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && kind >= 11) |=> (rdData == '0));

  // R6
  count_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && kind == 2) |=> (rdData[DATA_W-1:16] == '0));

  // R3
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && (kind == 0 || kind == 1 || kind == 8)) |=> (rdData[DATA_W-1:6] == '0));

  // R3
  match_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && kind >= 3 && kind <= 6) |=> (rdData[DATA_W-1:16] == '0));

  // R4
  evtval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && kind == 10) |=> (rdData == '0));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdEn && !$past(!rst_n)) |=> $stable(rdData));
endmodule

bind tri_timer_bank ttb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) uChk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rdEn   (rdEn),
  .addr   (addr),
  .rdData (rdData)
);

// File: tb/tri_timer_bank_test.sv
module tri_timer_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_timer_bank uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic expectRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    doRead(a, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    check("R2 rdData after reset", rdData, 32'h0);
    check("R9 irq after reset", {29'h0, irq}, 32'h0);
    expectRead("R2 cntctl ch0 reset", 8'h0C, 32'h21);
    expectRead("R2 cntctl ch2 reset", 8'h14, 32'h21);
    expectRead("R2 clk ch1 reset", 8'h04, 32'h0);
  endtask

  task automatic testDecode();
    doWrite(8'h28, 32'h1234);
    expectRead("R1 interval ch1", 8'h28, 32'h1234);
    expectRead("R1 interval ch0 untouched", 8'h24, 32'h0);
    expectRead("R1 interval ch2 untouched", 8'h2C, 32'h0);
    doWrite(8'h3C, 32'hAB);
    expectRead("R1 match B ch0", 8'h3C, 32'hAB);
    expectRead("R1 match B ch1 untouched", 8'h40, 32'h0);
  endtask

  task automatic testMasks();
    doWrite(8'h2C, 32'hFFFF_FFFF);
    expectRead("R3 interval mask", 8'h2C, 32'hFFFF);
    doWrite(8'h04, 32'hFFFF_FFFF);
    expectRead("R3 clk mask", 8'h04, 32'h3F);
    doWrite(8'h68, 32'hFFFF_FFFF);
    expectRead("R3 inten mask", 8'h68, 32'h3F);
    doWrite(8'h74, 32'hFFFF_FFFF);
    expectRead("R3 evtctl mask", 8'h74, 32'h7);
    doWrite(8'h14, 32'hFFFF_FFFF);
    expectRead("R10 zero bit not stored", 8'h14, 32'h2F);
  endtask

  task automatic testIgnored();
    doWrite(8'h20, 32'h55);
    expectRead("R4 count write ignored", 8'h20, 32'h0);
    doWrite(8'h5C, 32'h3F);
    check("R4 status write no irq", {31'h0, irq[2]}, 32'h0);
    expectRead("R4 status write ignored", 8'h5C, 32'h0);
    doWrite(8'h80, 32'h7);
    expectRead("R4 event value reads zero", 8'h80, 32'h0);
  endtask

  task automatic testUnmapped();
    doWrite(8'h84, 32'h3F);
    expectRead("R5 unmapped write ignored", 8'h00, 32'h0);
    expectRead("R5 unmapped read 0x84", 8'h84, 32'h0);
    expectRead("R5 unmapped read 0xFC", 8'hFC, 32'h0);
  endtask

  task automatic testInterval();
    doWrite(8'h24, 32'h4);
    doWrite(8'h60, 32'h01);
    doWrite(8'h0C, 32'h12);
    repeat (4) @(negedge clk);
    check("R11 no wrap before interval", {31'h0, irq[0]}, 32'h0);
    @(negedge clk);
    check("R11 interval wrap irq", {31'h0, irq[0]}, 32'h1);
    check("R9 other lines quiet", {30'h0, irq[2:1]}, 32'h0);
    doWrite(8'h0C, 32'h01);
    expectRead("R10 count after stop", 8'h18, 32'h1);
    expectRead("R7 status returns flag", 8'h54, 32'h01);
    check("R7 irq cleared by read", {31'h0, irq[0]}, 32'h0);
    expectRead("R7 status cleared", 8'h54, 32'h0);
  endtask

  task automatic testSameCycle();
    logic [31:0] d;
    doWrite(8'h28, 32'h4);
    doWrite(8'h64, 32'h01);
    doWrite(8'h10, 32'h12);
    repeat (4) @(negedge clk);
    doRead(8'h58, d);
    check("R8 read before flag returns 0", d, 32'h0);
    check("R8 flag kept after clear", {31'h0, irq[1]}, 32'h1);
    doWrite(8'h10, 32'h01);
    expectRead("R8 flag visible on next read", 8'h58, 32'h01);
  endtask

  task automatic testMatch();
    doWrite(8'h38, 32'h3);
    doWrite(8'h68, 32'h02);
    doWrite(8'h14, 32'h18);
    repeat (2) @(negedge clk);
    check("R12 no match yet", {31'h0, irq[2]}, 32'h0);
    @(negedge clk);
    check("R12 match A irq", {31'h0, irq[2]}, 32'h1);
    doWrite(8'h14, 32'h01);
    expectRead("R12 match A status bit", 8'h5C, 32'h02);
  endtask

  task automatic testDown();
    doWrite(8'h60, 32'h10);
    doWrite(8'h0C, 32'h14);
    @(negedge clk);
    check("R11 down wrap irq", {31'h0, irq[0]}, 32'h1);
    doWrite(8'h0C, 32'h01);
    expectRead("R6 count after down wrap", 8'h18, 32'hFFFE);
    expectRead("R11 overflow status bit", 8'h54, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testDecode();
    testMasks();
    testIgnored();
    testUnmapped();
    testInterval();
    testSameCycle();
    testMatch();
    testDown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule